// File: doc/BRIEF.md
# Pseudo-Random Streaming Frame Source

This block sources test frames on a ready/valid streaming interface that carries 32-bit words and has start-of-packet, end-of-packet and empty markers. It can feed a MAC transmit port directly. A pulse on `go` starts one frame. The block latches the seed and the payload length (a count of 32-bit words) when it accepts the pulse. It then emits the frame, keeps the same beat on the bus for as long as the sink holds `ready` low, and returns to idle after the final beat has been taken.

When the parameter `HDR_EN` is set, each frame opens with a fixed 14-byte link-layer header, so that a receiver does not discard it. The header holds the destination address, the source address and the type field, all taken from parameters. The payload bytes follow directly behind the header, so every later beat straddles two payload words. The payload words come from a rotate-and-add sequence. Each next word is the current word rotated left by five bits plus a fixed odd constant. The sequence steps only when the sink accepts a payload beat, which makes the byte stream independent of backpressure.

Top module: `rand_frame_src`

## Requirements
- R1: The first payload word equals the seed latched with `go`. Each following word is `{w[26:0], w[31:27]} + 32'h33557799` taken modulo 2^32, where `w` is the previous word.
- R2: The payload sequence steps only on accepted payload beats. Any pattern of `ready` yields the same byte stream as a sink that is always ready.
- R3: With `HDR_EN`=1, beats 0 to 2 carry `DST[47:16]`, `{DST[15:0], SRC[47:32]}` and `SRC[31:0]`. Beat 3 carries `{ETYPE, w0[31:16]}`. Each following payload beat carries `{w(i-1)[15:0], wi[31:16]}`, and the final beat carries `{w(N-1)[15:0], 16'h0000}`. All packing is big-endian: the earliest byte is in bits 31:24.
- R4: With `HDR_EN`=1, a frame has N+4 beats; with `HDR_EN`=0 it has N beats, where each beat is one word. A `pay_len` of 0 is taken as N=1.
- R5: `sop` is high only on the first beat of a frame, and `eop` only on its last beat.
- R6: `empty` gives the count of unused low-order bytes in the last beat: 2 with a header, 0 without one. It is 0 on every other beat.
- R7: While `valid` is high and `ready` is low, `valid`, `data`, `sop`, `eop` and `empty` hold their values into the next cycle.
- R8: `busy` rises in the cycle after `go` is accepted while idle, and falls after the final beat is accepted. A `go` seen while busy has no effect: it does not change the current frame and does not start a later one.
- R9: After reset `valid` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| go | input | 1 | Start request, taken only while idle |
| seed | input | 32 | First payload word, latched at start |
| pay_len | input | LEN_W | Payload length in 32-bit words (0 means 1) |
| ready | input | 1 | Sink can accept the current beat |
| valid | output | 1 | A beat is on the bus |
| data | output | 32 | Beat data, big-endian byte order |
| sop | output | 1 | First beat of a frame |
| eop | output | 1 | Last beat of a frame |
| empty | output | 2 | Unused bytes in the last beat |
| busy | output | 1 | A frame is in progress |

## Verification
Frames are drawn from two builds, one with the header and one without. Each build is driven by a sink that is always ready and by sinks that stall on alternate cycles or on two cycles out of every three. If all three sinks collect the same beats, the sequence steps only on accepted beats and not on every clock. The seeds include zero and all-ones, so the fixed added constant and the wrap at the top bit are both visible. Lengths of 0, 1 and several words cover the boundary where the last payload beat is also the first payload beat. A second `go` with a different seed is raised in the middle of a frame. It must not change the frame and must not start another.

// File: rtl/rand_frame_pkg.sv
package rand_frame_pkg;
    localparam int WORD_W = 32;
    localparam int HALF_W = WORD_W / 2;
    localparam int ROT_N = 5;
    localparam logic [WORD_W-1:0] ADD_K = 32'h33557799;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_DATA = 2'd2,
        ST_EOP  = 2'd3
    } fsm_e;

    function automatic logic [WORD_W-1:0] rot_add(input logic [WORD_W-1:0] w);
        return {w[WORD_W-ROT_N-1:0], w[WORD_W-1:WORD_W-ROT_N]} + ADD_K;
    endfunction
endpackage

// File: rtl/rotadd_gen.sv
module rotadd_gen
    import rand_frame_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] seed,
    input  logic              step,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (load)
            word_d = seed;
        else if (step)
            word_d = rot_add(word_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            word_q <= '0;
        else
            word_q <= word_d;
    end

    assign word = word_q;

    // R2: without a load or a step the word must not move
    a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(word_q));
endmodule

// File: rtl/hdr_beats.sv
module hdr_beats
    import rand_frame_pkg::*;
#(
    parameter logic [47:0] DST = 48'h02_00_5E_00_00_01,
    parameter logic [47:0] SRC = 48'h02_00_5E_00_00_02
) (
    input  logic [1:0]        idx,
    output logic [WORD_W-1:0] word
);
    always_comb begin
        unique case (idx)
            2'd0:    word = DST[47:16];
            2'd1:    word = {DST[15:0], SRC[47:32]};
            default: word = SRC[31:0];
        endcase
    end
endmodule

// File: rtl/rand_frame_src.sv
module rand_frame_src
    import rand_frame_pkg::*;
#(
    parameter int          LEN_W  = 8,
    parameter bit          HDR_EN = 1'b1,
    parameter logic [47:0] DST    = 48'h02_00_5E_00_00_01,
    parameter logic [47:0] SRC    = 48'h02_00_5E_00_00_02,
    parameter logic [15:0] ETYPE  = 16'h88B5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [31:0]       seed,
    input  logic [LEN_W-1:0]  pay_len,
    input  logic              ready,
    output logic              valid,
    output logic [31:0]       data,
    output logic              sop,
    output logic              eop,
    output logic [1:0]        empty,
    output logic              busy
);
    localparam logic [1:0] HDR_LAST = 2'd2;
    localparam logic [1:0] EMPTY_TAIL = HDR_EN ? 2'd2 : 2'd0;

    typedef struct packed {
        fsm_e              st;
        logic [1:0]        idx;
        logic [LEN_W-1:0]  cnt;
        logic [HALF_W-1:0] carry;
        logic              first;
        logic              busy;
    } seq_t;

    seq_t s_d, s_q;
    logic gen_load, gen_step, accept;
    logic [WORD_W-1:0] gen_word, hdr_word;
    logic [LEN_W-1:0] len_eff;

    rotadd_gen u_gen (
        .clk  (clk),
        .rst_n(rst_n),
        .load (gen_load),
        .seed (seed),
        .step (gen_step),
        .word (gen_word)
    );

    hdr_beats #(.DST(DST), .SRC(SRC)) u_hdr (
        .idx (s_q.idx),
        .word(hdr_word)
    );

    assign len_eff = (pay_len == '0) ? LEN_W'(1) : pay_len;
    assign valid   = (s_q.st != ST_IDLE);
    assign accept  = valid && ready;

    always_comb begin
        s_d      = s_q;
        gen_load = 1'b0;
        gen_step = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (go) begin
                    gen_load  = 1'b1;
                    s_d.busy  = 1'b1;
                    s_d.first = 1'b1;
                    s_d.cnt   = len_eff;
                    s_d.idx   = '0;
                    s_d.carry = ETYPE;
                    if (HDR_EN)
                        s_d.st = ST_HDR;
                    else
                        s_d.st = (len_eff == LEN_W'(1)) ? ST_EOP : ST_DATA;
                end
            end
            ST_HDR: begin
                if (accept) begin
                    s_d.first = 1'b0;
                    if (s_q.idx == HDR_LAST)
                        s_d.st = ST_DATA;
                    else
                        s_d.idx = s_q.idx + 2'd1;
                end
            end
            ST_DATA: begin
                if (accept) begin
                    gen_step  = 1'b1;
                    s_d.first = 1'b0;
                    s_d.carry = gen_word[HALF_W-1:0];
                    s_d.cnt   = s_q.cnt - LEN_W'(1);
                    if (s_q.cnt == (HDR_EN ? LEN_W'(1) : LEN_W'(2)))
                        s_d.st = ST_EOP;
                end
            end
            default: begin
                if (accept) begin
                    gen_step  = 1'b1;
                    s_d.first = 1'b0;
                    s_d.busy  = 1'b0;
                    s_d.st    = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            s_q <= '{st: ST_IDLE, idx: '0, cnt: '0, carry: '0, first: 1'b0, busy: 1'b0};
        else
            s_q <= s_d;
    end

    always_comb begin
        data  = '0;
        empty = 2'd0;
        unique case (s_q.st)
            ST_HDR:  data = hdr_word;
            ST_DATA: data = HDR_EN ? {s_q.carry, gen_word[WORD_W-1:HALF_W]} : gen_word;
            ST_EOP: begin
                data  = HDR_EN ? {s_q.carry, {HALF_W{1'b0}}} : gen_word;
                empty = EMPTY_TAIL;
            end
            default: data = '0;
        endcase
    end

    assign sop  = valid && s_q.first;
    assign eop  = (s_q.st == ST_EOP);
    assign busy = s_q.busy;

    // R7: a stalled beat is held unchanged
    a_r7_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> (valid && $stable(data) && $stable(sop)
                               && $stable(eop) && $stable(empty)));
    // R5: the bus goes quiet right after a taken end-of-packet beat
    a_r5_eop_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ready && eop) |=> !valid);
    // R6: empty is zero away from the final beat
    a_r6_empty_mid: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !eop) |-> (empty == 2'd0));
    // R8: a beat is only offered while busy
    a_r8_valid_busy: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> busy);
    // R8: go while idle starts a frame on the next cycle
    a_r8_go_start: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !busy) |=> (busy && valid && sop));
endmodule

// File: tb/rand_frame_src_tb_top.sv
module rand_frame_src_tb_top;
    localparam logic [47:0] DST_T = 48'hA1B2_C3D4_E5F6;
    localparam logic [47:0] SRC_T = 48'h0123_4567_89AB;
    localparam logic [15:0] ET_T  = 16'h88B5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic go_h = 1'b0, go_n = 1'b0;
    logic [31:0] seed = '0;
    logic [7:0] pay_len = '0;
    logic ready = 1'b0;

    logic v_h, s_h, e_h, b_h, v_n, s_n, e_n, b_n;
    logic [31:0] d_h, d_n;
    logic [1:0] m_h, m_n;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    rand_frame_src #(.LEN_W(8), .HDR_EN(1'b1), .DST(DST_T), .SRC(SRC_T), .ETYPE(ET_T)) dut_i (
        .clk(clk), .rst_n(rst_n), .go(go_h), .seed(seed), .pay_len(pay_len),
        .ready(ready), .valid(v_h), .data(d_h), .sop(s_h), .eop(e_h),
        .empty(m_h), .busy(b_h));

    rand_frame_src #(.LEN_W(8), .HDR_EN(1'b0), .DST(DST_T), .SRC(SRC_T), .ETYPE(ET_T)) dut_nh_i (
        .clk(clk), .rst_n(rst_n), .go(go_n), .seed(seed), .pay_len(pay_len),
        .ready(ready), .valid(v_n), .data(d_n), .sop(s_n), .eop(e_n),
        .empty(m_n), .busy(b_n));

    function automatic logic [31:0] nxt(input logic [31:0] w);
        return {w[26:0], w[31:27]} + 32'h33557799;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        finish_run();
    end

    // One frame from the selected build; bp: 0 always ready, 1 alternate, 2 one in three
    task automatic run_frame(input bit hdr, input logic [31:0] sd, input logic [7:0] len,
                             input int bp, input bit poke);
        logic [31:0] w [0:63];
        logic [31:0] exp_d [0:67];
        int nw, nb, got, cyc;
        logic pv, pr, cv, cs, ce, cb;
        logic [31:0] pd, cd;
        logic [1:0] cm;
        nw = (len == 0) ? 1 : int'(len);
        w[0] = sd;
        for (int i = 1; i < nw; i++) w[i] = nxt(w[i-1]);
        if (hdr) begin
            exp_d[0] = DST_T[47:16];
            exp_d[1] = {DST_T[15:0], SRC_T[47:32]};
            exp_d[2] = SRC_T[31:0];
            exp_d[3] = {ET_T, w[0][31:16]};
            for (int i = 1; i < nw; i++) exp_d[3+i] = {w[i-1][15:0], w[i][31:16]};
            exp_d[3+nw] = {w[nw-1][15:0], 16'h0000};
            nb = nw + 4;
        end else begin
            for (int i = 0; i < nw; i++) exp_d[i] = w[i];
            nb = nw;
        end
        @(negedge clk);
        seed = sd; pay_len = len;
        if (hdr) go_h = 1'b1; else go_n = 1'b1;
        @(negedge clk);
        go_h = 1'b0; go_n = 1'b0;
        seed = ~sd; pay_len = 8'd3;
        cb = hdr ? b_h : b_n;
        chk(cb === 1'b1, "R8 busy after go", {31'd0, cb}, 32'd1);
        got = 0; cyc = 0; pv = 1'b0; pr = 1'b1; pd = '0;
        while (got < nb && cyc < 2000) begin
            ready = (bp == 0) ? 1'b1 : (bp == 1) ? cyc[0] : (cyc % 3 == 2);
            if (poke && got == 2) begin
                if (hdr) go_h = 1'b1; else go_n = 1'b1;
            end else begin
                go_h = 1'b0; go_n = 1'b0;
            end
            cv = hdr ? v_h : v_n; cd = hdr ? d_h : d_n;
            cs = hdr ? s_h : s_n; ce = hdr ? e_h : e_n; cm = hdr ? m_h : m_n;
            if (pv && !pr)
                chk(cv === 1'b1 && cd === pd, "R7 stalled beat held", cd, pd);
            if (cv && ready) begin
                chk(cd === exp_d[got], hdr ? "R1 R2 R3 beat data" : "R1 R2 beat data",
                    cd, exp_d[got]);
                chk(cs === (got == 0) && ce === (got == nb - 1), "R5 sop/eop marks",
                    {30'd0, cs, ce}, {30'd0, got == 0, got == nb - 1});
                chk(cm === ((got == nb - 1 && hdr) ? 2'd2 : 2'd0), "R6 empty count",
                    {30'd0, cm}, (got == nb - 1 && hdr) ? 32'd2 : 32'd0);
                got++;
            end
            pv = cv; pr = ready; pd = cd;
            cyc++;
            @(negedge clk);
        end
        go_h = 1'b0; go_n = 1'b0;
        ready = 1'b1;
        chk(got == nb, "R4 beat count", got, nb);
        cb = hdr ? b_h : b_n;
        chk(cb === 1'b0, "R8 busy clears after last beat", {31'd0, cb}, 32'd0);
        for (int k = 0; k < 3; k++) begin
            cv = hdr ? v_h : v_n;
            chk(cv === 1'b0, "R8 no extra frame", {31'd0, cv}, 32'd0);
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(v_h === 1'b0 && v_n === 1'b0, "R9 valid low in reset", {31'd0, v_h | v_n}, 32'd0);
        chk(b_h === 1'b0 && b_n === 1'b0, "R9 busy low in reset", {31'd0, b_h | b_n}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(v_h === 1'b0 && b_h === 1'b0, "R9 idle after reset", {31'd0, v_h | b_h}, 32'd0);
    endtask

    task automatic t_header_frames();
        run_frame(1'b1, 32'h0000_0000, 8'd5, 0, 1'b0);
        run_frame(1'b1, 32'hFFFF_FFFF, 8'd6, 1, 1'b0);
        run_frame(1'b1, 32'h1234_5678, 8'd4, 2, 1'b0);
    endtask

    task automatic t_plain_frames();
        run_frame(1'b0, 32'hDEAD_BEEF, 8'd7, 0, 1'b0);
        run_frame(1'b0, 32'h8000_0001, 8'd5, 2, 1'b0);
    endtask

    task automatic t_short_lengths();
        run_frame(1'b1, 32'hCAFE_0001, 8'd1, 1, 1'b0);
        run_frame(1'b1, 32'hCAFE_0002, 8'd0, 0, 1'b0);
        run_frame(1'b0, 32'hCAFE_0003, 8'd1, 2, 1'b0);
        run_frame(1'b0, 32'hCAFE_0004, 8'd0, 1, 1'b0);
    endtask

    task automatic t_go_while_busy();
        run_frame(1'b1, 32'h5555_AAAA, 8'd6, 1, 1'b1);
        run_frame(1'b0, 32'hA5A5_5A5A, 8'd6, 0, 1'b1);
    endtask

    initial begin
        t_reset();
        t_header_frames();
        t_plain_frames();
        t_short_lengths();
        t_go_while_busy();
        finish_run();
    end
endmodule